// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous memory with late-write timing. On every rising clock edge it samples a chip select, a write enable, a word address and one enable bit per byte lane. For a write, the data word is supplied one cycle later than the command and is captured on the following rising edge. Reads are register-to-register: the address is registered on one edge and the word appears in an output register after the next edge, together with an output-enable flag that tells the surrounding logic when to drive the bus.

A posted-write buffer holds the most recent write (address, lane enables and data). That entry moves into the storage array when the data of the next write is captured. A read that targets the buffered address takes the enabled lanes from the buffer and the remaining lanes from the array, so every read sees all earlier writes. Reads and writes can therefore be interleaved in any order at full clock rate. An asynchronous, active-high sleep input stops new commands from being accepted and forces the output enable low at once. Stored data is kept.

Top module: `lw_sram`

## Requirements
- R1: While reset is high and after it is released, `rd_oe` is 0 and `rdata` is all zeros until the first read completes.
- R2: A read is accepted when `cs`=1, `we`=0 and `sleep`=0 at a rising edge N. After edge N+1, `rd_oe` is 1 and `rdata` holds the word at that address.
- R3: A write is accepted when `cs`=1, `we`=1 and `sleep`=0 at edge N. Its data word is taken from `wdata` at edge N+1, whatever the command inputs are at that edge.
- R4: Bit i of `be` covers lane i, which is `wdata`/`rdata` bits [9i+8:9i]. A write changes only the lanes whose enable bit is 1, and a write with `be`=0 changes nothing.
- R5: A read whose address equals the pending buffered write returns buffer data for that write's enabled lanes and previously stored data for the other lanes. This holds when the read is issued in the same cycle the write data is supplied.
- R6: The buffered write is committed to the array when the next write's data is captured. Data stays readable after any number of later writes to other addresses.
- R7: When `cs`=0 at an edge, no command is accepted: two edges later `rd_oe` is 0 and no stored word changes.
- R8: While `sleep`=1, no command is accepted, and `rd_oe` is 0 without waiting for a clock edge. Stored contents are kept across sleep.
- R9: Any mix of reads and writes, including read-write-read on the same address, runs at one command per cycle with no idle cycles, and each read returns the latest written data.
- R10: `rdata` keeps its last read value across cycles in which no read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Asynchronous active-high sleep request |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | 1 = write command, 0 = read command |
| addr | input | ADDR_W (4) | Word address |
| be | input | LANES (4) | Lane write enables, bit i for lane i |
| wdata | input | LANES*LANE_W (36) | Write data, one cycle after its command |
| rdata | output | LANES*LANE_W (36) | Registered read data |
| rd_oe | output | 1 | Output enable for the read data |

## Verification
On every cycle the assertions check the following: the read-latency relation between an accepted read and `rd_oe`, that `rd_oe` never rises without a read two edges earlier, that it stays low during sleep, that `rdata` holds when no read completes, and that an array commit only follows an accepted write. Data correctness cannot be stated as a simple property. This covers byte merging against the pending buffer, commit ordering across many writes, and contents kept through deselect and sleep. Only the bench's scenarios show these. It sweeps every address with every lane-enable pattern and a long pseudo-random mix, and compares each read against a byte-level memory model.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Command latched at the sampling edge
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int DEF_ADDR_W = 4;
    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 9;

    function automatic op_e decode_op(input logic sel, input logic wr, input logic slp);
        if (!sel || slp)
            return OP_NONE;
        return wr ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  be_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_NONE;
            addr_q <= '0;
            be_q   <= '0;
        end else begin
            op_q   <= decode_op(cs, we, sleep);
            addr_q <= addr;
            be_q   <= be;
        end
    end

endmodule

// File: rtl/lw_post_buffer.sv
module lw_post_buffer #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [LANES-1:0]        ld_be,
    input  logic [LANES*LANE_W-1:0] ld_data,
    input  logic [ADDR_W-1:0]       look_addr,
    input  logic [LANES*LANE_W-1:0] base_word,
    output logic                    commit_en,
    output logic [ADDR_W-1:0]       commit_addr,
    output logic [LANES-1:0]        commit_be,
    output logic [LANES*LANE_W-1:0] commit_data,
    output logic [LANES*LANE_W-1:0] merged
);

    logic                    held_v;
    logic [ADDR_W-1:0]       held_a;
    logic [LANES-1:0]        held_be;
    logic [LANES*LANE_W-1:0] held_d;
    logic                    hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v  <= 1'b0;
            held_a  <= '0;
            held_be <= '0;
            held_d  <= '0;
        end else if (load) begin
            held_v  <= 1'b1;
            held_a  <= ld_addr;
            held_be <= ld_be;
            held_d  <= ld_data;
        end
    end

    // Old entry leaves for the array as the new one arrives
    assign commit_en   = load && held_v;
    assign commit_addr = held_a;
    assign commit_be   = held_be;
    assign commit_data = held_d;

    assign hit = held_v && (held_a == look_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = (hit && held_be[i])
            ? held_d[i*LANE_W +: LANE_W]
            : base_word[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_store.sv
module lw_store #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES*LANE_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < LANES; i++) begin : g_wlane
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[i])
                cells[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
        end
    end

    assign rd_word = cells[rd_addr];

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep,
    input  logic                    cs,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_oe
);

    localparam int DW = LANES * LANE_W;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [LANES-1:0]  commit_be;
    logic [DW-1:0]     commit_data;
    logic [DW-1:0]     array_word;
    logic [DW-1:0]     merged;
    logic [DW-1:0]     rdata_q;
    logic              rd_oe_q;

    lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk(clk), .rst(rst), .sleep(sleep), .cs(cs), .we(we),
        .addr(addr), .be(be),
        .op_q(op_q), .addr_q(addr_q), .be_q(be_q)
    );

    lw_post_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_buf (
        .clk(clk), .rst(rst),
        .load(op_q == OP_WRITE), .ld_addr(addr_q), .ld_be(be_q), .ld_data(wdata),
        .look_addr(addr_q), .base_word(array_word),
        .commit_en(commit_en), .commit_addr(commit_addr),
        .commit_be(commit_be), .commit_data(commit_data),
        .merged(merged)
    );

    lw_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk),
        .wr_en(commit_en), .wr_addr(commit_addr), .wr_be(commit_be), .wr_data(commit_data),
        .rd_addr(addr_q), .rd_word(array_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_oe_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            rd_oe_q <= (op_q == OP_READ);
            if (op_q == OP_READ)
                rdata_q <= merged;
        end
    end

    assign rdata = rdata_q;
    assign rd_oe = rd_oe_q & ~sleep;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          sleep,
    input logic          cs,
    input logic          we,
    input logic          rd_oe,
    input logic          rd_oe_q,
    input logic [DW-1:0] rdata,
    input logic          commit_en
);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && !sleep) |=> ##1 (rd_oe || sleep)); // R2

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> $past(cs && !we && !sleep, 2)); // R7

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rd_oe); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_oe_q |-> $stable(rdata)); // R10

    AST_COMMIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> $past(cs && we && !sleep)); // R6

endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .cs(cs), .we(we),
    .rd_oe(rd_oe), .rd_oe_q(rd_oe_q), .rdata(rdata), .commit_en(commit_en)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;

    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep = 1'b0;
    logic          cs = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] be = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_oe;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .sleep(sleep), .cs(cs), .we(we),
        .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe)
    );

    // Byte-level model, updated as soon as a write's data is known
    logic [DW-1:0] model [DEPTH];
    logic          pend_w = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [NL-1:0] pend_b = '0;
    logic [DW-1:0] last_rd = '0;
    logic [31:0]   lfsr = 32'h1ACE_B00C;

    logic          ring_rd  [4];
    logic [DW-1:0] ring_dat [4];
    string         ring_tag [4];
    int            cyc = 0;

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic chk1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One command cycle; called at a falling edge, returns at the next one
    task automatic step(input logic c, input logic w, input logic [AW-1:0] a,
                        input logic [NL-1:0] b, input logic s, input string tag);
        logic [DW-1:0] d;
        logic          acc;
        int            k;
        if (cyc >= 2) begin
            k = (cyc - 2) % 4;
            chk1({ring_tag[k], " oe"}, {35'd0, rd_oe}, {35'd0, ring_rd[k] && !sleep});
            if (ring_rd[k]) begin
                chk1(ring_tag[k], rdata, ring_dat[k]);
                last_rd = ring_dat[k];
            end else begin
                chk1("R10", rdata, last_rd);
            end
        end
        lfsr = nxt(lfsr);
        d = {lfsr[3:0], lfsr ^ 32'h5A5A_A5A5};
        lfsr = nxt(lfsr);
        if (pend_w)
            for (int i = 0; i < NL; i++)
                if (pend_b[i]) model[pend_a][i*LW +: LW] = d[i*LW +: LW];
        acc = c && !s;
        k = cyc % 4;
        ring_rd[k]  = acc && !w;
        ring_dat[k] = model[a];
        ring_tag[k] = tag;
        pend_w = acc && w;
        pend_a = a;
        pend_b = b;
        cs = c; we = w; addr = a; be = b; sleep = s; wdata = d;
        if (s) begin
            #1;
            chk1("R8 async", {35'd0, rd_oe}, '0);
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk1("R1 oe in reset", {35'd0, rd_oe}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk1("R1 oe", {35'd0, rd_oe}, '0);
        chk1("R1 data", rdata, '0);

        // Full-word writes to every address, then read back
        for (int a = 0; a < DEPTH; a++) step(1, 1, a[AW-1:0], '1, 0, "R3");
        step(0, 0, '0, '0, 0, "R7");
        for (int a = 0; a < DEPTH; a++) step(1, 0, a[AW-1:0], '0, 0, "R3");

        // Every lane pattern on every address, with forwarding
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < (1 << NL); b++) begin
                step(1, 1, a[AW-1:0], b[NL-1:0], 0, "R4");
                step(1, 0, a[AW-1:0], '0, 0, "R5");
                step(1, 0, a[AW-1:0] ^ 1'b1, '0, 0, "R6");
                step(1, 0, a[AW-1:0], '0, 0, "R5");
            end
        for (int a = 0; a < DEPTH; a++) step(1, 0, a[AW-1:0], '0, 0, "R6");

        // Back-to-back read-write-read on one address
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 0, a[AW-1:0], '0, 0, "R9");
            step(1, 1, a[AW-1:0], 4'b0101, 0, "R9");
            step(1, 0, a[AW-1:0], '0, 0, "R9");
            step(1, 1, a[AW-1:0], 4'b1010, 0, "R9");
            step(1, 0, a[AW-1:0], '0, 0, "R9");
        end

        // Deselected and sleeping writes must not land
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 1, a[AW-1:0], '1, 0, "R7");
            step(1, 1, a[AW-1:0], '1, 1, "R8");
            step(1, 0, a[AW-1:0], '1, 1, "R8");
            step(1, 0, a[AW-1:0], '0, 0, "R8");
        end

        // Pseudo-random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            lfsr = nxt(lfsr);
            r = lfsr;
            step(r[0] | r[1], r[2], r[6:3], r[10:7], (r[15:11] == 5'd0), "R9");
        end

        repeat (3) step(0, 0, '0, '0, 0, "R7");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule